// File: doc/BRIEF.md
# Image Sensor Readout Raster Timing Generator

This block produces the pixel-clock raster for reading out a Bayer-pattern image sensor. It walks a line counter and a frame counter. From their state it drives horizontal and vertical sync, a pixel-valid strobe, a flag for the two dark lines, the current row and column, and a two-bit colour tag for every pixel. The block handles timing and position tags only. The pixel values themselves travel on a separate path that uses these strobes as qualifiers, and the pixel values are don't-care outside the strobe.

Each line begins with a leading blank run. A guard gap follows, then a bordered window of 644 pixels (a 640-pixel image with a 2-pixel border on each side), then a second guard gap. Software lengthens a line by adding clocks to the leading run, and the guards and window stay fixed. Each frame starts with one dark line, then 484 valid lines, then one more dark line. Any further lines the frame-length setting asks for come out as blank lines. Both lengths are clamped to hardware limits, and the block picks up new values only when a frame wraps.

Top module: `readout_timing`

## Requirements
- R1: While reset is held, and on the first clock after it is released, the raster is at line position 0 of row 0. In that state pixValid, hSync and darkLine are 0, rowIdx and colIdx are 0, and the frame in progress uses the minimum line length (772) and the minimum frame length (486).
- R2: Let L be the line length in effect. The leading blank run lasts L-652 clocks, from line position 0. It is followed by 4 guard clocks, 644 window clocks and 4 guard clocks, so the window covers line positions L-648 up to L-5.
- R3: The effective line length is cfgLineLen clamped to the range 772 to 1156. It is sampled only on the last clock of a frame and applies from the next frame onward. A change during a frame has no effect on that frame.
- R4: rowIdx gives the line number within the frame, counting from 0. Row 0 and row 485 are dark lines, rows 1 to 484 are valid lines, and any higher row is a blank line with no window output.
- R5: The effective frame length is cfgFrameLen, raised to 486 if it is lower. It is sampled only on the last clock of a frame and applies from the next frame onward.
- R6: vSync is high only on row 0, for the 120 clocks at line positions L-772 up to L-653. Its rising edge therefore comes 120 clocks before the first guard gap of the frame's first line.
- R7: hSync and pixValid are both high on exactly the window clocks of dark and valid lines, and low at every other clock.
- R8: darkLine is high on exactly the window clocks of rows 0 and 485.
- R9: During the window, colIdx counts 0 to 643, one step per clock. Outside the window it reads 0.
- R10: On window clocks of valid lines with monochrome low, colorTag gives the Bayer colour. On odd rows (blue rows, starting with row 1), even columns are 00 (B) and odd columns are 01 (G). On even rows (red rows), even columns are 10 (G) and odd columns are 11 (R). In every other case colorTag is 00, including whenever monochrome is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgLineLen | input | 11 | Requested clocks per line (clamped 772..1156) |
| cfgFrameLen | input | 12 | Requested lines per frame (minimum 486) |
| monochrome | input | 1 | Forces colorTag to 00 |
| hSync | output | 1 | High during the window of each output line |
| vSync | output | 1 | Frame sync pulse on row 0 |
| pixValid | output | 1 | Pixel-valid strobe |
| darkLine | output | 1 | Window of a dark line |
| rowIdx | output | 12 | Line number within the frame |
| colIdx | output | 10 | Column within the bordered window |
| colorTag | output | 2 | Bayer colour of the current pixel |

## Verification
The bench builds the block with a scaled-down raster: an 8-pixel window, 2-clock guards, a 6-clock minimum leading run with up to 10 extra clocks, and 4 valid lines. That gives an 18-clock minimum line and a 6-line minimum frame. With these sizes a single run covers dozens of frames. Within reach are requests below both minimums and above the line maximum, blank lines between frames, configuration changes in the middle of a frame, and monochrome switching, all compared clock by clock against a behavioural model.

// File: rtl/readout_timing_pkg.sv
package readout_timing_pkg;

  typedef enum logic [1:0] {
    LN_DARK  = 2'd0,
    LN_VALID = 2'd1,
    LN_BLANK = 2'd2
  } lineKind_t;

  typedef struct packed {
    logic      inWindow;
    logic      vsWin;
    lineKind_t kind;
    logic      redRow;
  } rasterStrobes_t;

endpackage

// File: rtl/rt_ctrl.sv
module rt_ctrl
  import readout_timing_pkg::*;
#(
  parameter int ACT_COLS    = 644,
  parameter int GUARD       = 4,
  parameter int MIN_LEAD    = 120,
  parameter int EXTRA_MAX   = 384,
  parameter int VALID_LINES = 484,
  parameter int FRAME_W     = 12,
  localparam int MIN_LINE   = MIN_LEAD + 2 * GUARD + ACT_COLS,
  localparam int MAX_LINE   = MIN_LINE + EXTRA_MAX,
  localparam int MIN_FRAME  = VALID_LINES + 2,
  localparam int HW         = $clog2(MAX_LINE + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HW-1:0]      cfgLineLen,
  input  logic [FRAME_W-1:0] cfgFrameLen,
  output rasterStrobes_t     strobes,
  output logic [FRAME_W-1:0] rowCnt
);

  logic [HW-1:0]      hCnt;
  logic [HW-1:0]      lineLenQ;
  logic [FRAME_W-1:0] frameLenQ;
  logic [HW-1:0]      lineLenNext;
  logic [FRAME_W-1:0] frameLenNext;
  logic [HW-1:0]      leadLen;
  logic [HW-1:0]      winStart;
  logic [HW-1:0]      winEnd;
  logic [HW-1:0]      vsStart;
  logic               lineWrap;
  logic               frameWrap;

  always_comb begin
    if (cfgLineLen < HW'(MIN_LINE))      lineLenNext = HW'(MIN_LINE);
    else if (cfgLineLen > HW'(MAX_LINE)) lineLenNext = HW'(MAX_LINE);
    else                                 lineLenNext = cfgLineLen;
    frameLenNext = (cfgFrameLen < FRAME_W'(MIN_FRAME)) ? FRAME_W'(MIN_FRAME) : cfgFrameLen;
  end

  assign leadLen   = lineLenQ - HW'(ACT_COLS + 2 * GUARD);
  assign winStart  = leadLen + HW'(GUARD);
  assign winEnd    = winStart + HW'(ACT_COLS);
  assign vsStart   = leadLen - HW'(MIN_LEAD);
  assign lineWrap  = (hCnt == lineLenQ - HW'(1));
  assign frameWrap = lineWrap && (rowCnt == frameLenQ - FRAME_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt      <= '0;
      rowCnt    <= '0;
      lineLenQ  <= HW'(MIN_LINE);
      frameLenQ <= FRAME_W'(MIN_FRAME);
    end else if (frameWrap) begin
      hCnt      <= '0;
      rowCnt    <= '0;
      lineLenQ  <= lineLenNext;
      frameLenQ <= frameLenNext;
    end else if (lineWrap) begin
      hCnt   <= '0;
      rowCnt <= rowCnt + FRAME_W'(1);
    end else begin
      hCnt <= hCnt + HW'(1);
    end
  end

  always_comb begin
    strobes.inWindow = (hCnt >= winStart) && (hCnt < winEnd);
    strobes.vsWin    = (rowCnt == '0) && (hCnt >= vsStart) && (hCnt < leadLen);
    if (rowCnt == '0 || rowCnt == FRAME_W'(VALID_LINES + 1)) strobes.kind = LN_DARK;
    else if (rowCnt <= FRAME_W'(VALID_LINES))                strobes.kind = LN_VALID;
    else                                                     strobes.kind = LN_BLANK;
    strobes.redRow   = ~rowCnt[0];
  end

endmodule

// File: rtl/rt_datapath.sv
module rt_datapath
  import readout_timing_pkg::*;
#(
  parameter int ACT_COLS = 644,
  localparam int CW      = $clog2(ACT_COLS)
) (
  input  logic           clk,
  input  logic           rstN,
  input  rasterStrobes_t strobes,
  input  logic           monochrome,
  output logic           hSync,
  output logic           vSync,
  output logic           pixValid,
  output logic           darkLine,
  output logic [CW-1:0]  colIdx,
  output logic [1:0]     colorTag
);

  logic [CW-1:0] colCnt;
  logic          lineShown;

  always_ff @(posedge clk) begin
    if (!rstN)                 colCnt <= '0;
    else if (strobes.inWindow) colCnt <= (colCnt == CW'(ACT_COLS - 1)) ? '0 : colCnt + CW'(1);
  end

  assign lineShown = strobes.inWindow && (strobes.kind != LN_BLANK);

  always_comb begin
    hSync    = lineShown;
    pixValid = lineShown;
    vSync    = strobes.vsWin;
    darkLine = strobes.inWindow && (strobes.kind == LN_DARK);
    colIdx   = strobes.inWindow ? colCnt : '0;
    if (strobes.inWindow && strobes.kind == LN_VALID && !monochrome)
      colorTag = {strobes.redRow, colCnt[0]};
    else
      colorTag = 2'b00;
  end

endmodule

// File: rtl/readout_timing.sv
module readout_timing
  import readout_timing_pkg::*;
#(
  parameter int ACT_COLS    = 644,
  parameter int GUARD       = 4,
  parameter int MIN_LEAD    = 120,
  parameter int EXTRA_MAX   = 384,
  parameter int VALID_LINES = 484,
  parameter int FRAME_W     = 12,
  localparam int HW         = $clog2(MIN_LEAD + 2 * GUARD + ACT_COLS + EXTRA_MAX + 1),
  localparam int CW         = $clog2(ACT_COLS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HW-1:0]      cfgLineLen,
  input  logic [FRAME_W-1:0] cfgFrameLen,
  input  logic               monochrome,
  output logic               hSync,
  output logic               vSync,
  output logic               pixValid,
  output logic               darkLine,
  output logic [FRAME_W-1:0] rowIdx,
  output logic [CW-1:0]      colIdx,
  output logic [1:0]         colorTag
);

  rasterStrobes_t strobes;

  rt_ctrl #(
    .ACT_COLS(ACT_COLS), .GUARD(GUARD), .MIN_LEAD(MIN_LEAD),
    .EXTRA_MAX(EXTRA_MAX), .VALID_LINES(VALID_LINES), .FRAME_W(FRAME_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgLineLen(cfgLineLen), .cfgFrameLen(cfgFrameLen),
    .strobes(strobes), .rowCnt(rowIdx)
  );

  rt_datapath #(.ACT_COLS(ACT_COLS)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .monochrome(monochrome),
    .hSync(hSync), .vSync(vSync), .pixValid(pixValid), .darkLine(darkLine),
    .colIdx(colIdx), .colorTag(colorTag)
  );

endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int ACT_COLS    = 644,
  parameter int VALID_LINES = 484,
  parameter int FRAME_W     = 12,
  localparam int CW         = $clog2(ACT_COLS)
) (
  input logic               clk,
  input logic               rstN,
  input logic               monochrome,
  input logic               vSync,
  input logic               pixValid,
  input logic               darkLine,
  input logic [FRAME_W-1:0] rowIdx,
  input logic [CW-1:0]      colIdx,
  input logic [1:0]         colorTag
);

  assert_col_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pixValid) |-> colIdx == '0);

  assert_col_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && colIdx != CW'(ACT_COLS - 1)) |=> (pixValid && colIdx == $past(colIdx) + CW'(1)));

  assert_window_end_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && colIdx == CW'(ACT_COLS - 1)) |=> !pixValid);

  assert_dark_rows_R8: assert property (@(posedge clk) disable iff (!rstN)
    darkLine |-> (pixValid && (rowIdx == '0 || rowIdx == FRAME_W'(VALID_LINES + 1))));

  assert_vs_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    vSync |-> (!pixValid && rowIdx == '0));

  assert_tag_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (colorTag != 2'b00) |-> (pixValid && !darkLine && !monochrome));

  assert_row_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> (rowIdx == $past(rowIdx)));

  assert_blank_rows_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rowIdx > FRAME_W'(VALID_LINES + 1)) |-> !pixValid);

endmodule

bind readout_timing rt_checker #(
  .ACT_COLS(ACT_COLS), .VALID_LINES(VALID_LINES), .FRAME_W(FRAME_W)
) uChk (
  .clk(clk), .rstN(rstN), .monochrome(monochrome), .vSync(vSync),
  .pixValid(pixValid), .darkLine(darkLine), .rowIdx(rowIdx),
  .colIdx(colIdx), .colorTag(colorTag)
);

// File: tb/sim_readout_timing.sv
`timescale 1ns/1ps
module sim_readout_timing;

  localparam int ACT = 8, GRD = 2, LEAD = 6, EXTRA = 10, VALID = 4, FW = 5;
  localparam int MINL = LEAD + 2 * GRD + ACT;
  localparam int MAXL = MINL + EXTRA;
  localparam int MINF = VALID + 2;
  localparam int HW = $clog2(MAXL + 1);
  localparam int CW = $clog2(ACT);

  logic clk = 0;
  logic rstN = 0;
  logic [HW-1:0] cfgLineLen = HW'(MINL);
  logic [FW-1:0] cfgFrameLen = FW'(MINF);
  logic monochrome = 0;
  logic hSync, vSync, pixValid, darkLine;
  logic [FW-1:0] rowIdx;
  logic [CW-1:0] colIdx;
  logic [1:0] colorTag;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  int mH = 0, mV = 0, mL = MINL, mF = MINF;

  always #2.5 clk = ~clk;

  readout_timing #(.ACT_COLS(ACT), .GUARD(GRD), .MIN_LEAD(LEAD), .EXTRA_MAX(EXTRA),
                   .VALID_LINES(VALID), .FRAME_W(FW)) u0 (
    .clk(clk), .rstN(rstN), .cfgLineLen(cfgLineLen), .cfgFrameLen(cfgFrameLen),
    .monochrome(monochrome), .hSync(hSync), .vSync(vSync), .pixValid(pixValid),
    .darkLine(darkLine), .rowIdx(rowIdx), .colIdx(colIdx), .colorTag(colorTag));

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s t=%0t act=%0d exp=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic int clampLine(input int v);
    return (v < MINL) ? MINL : ((v > MAXL) ? MAXL : v);
  endfunction

  function automatic int clampFrame(input int v);
    return (v < MINF) ? MINF : v;
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  // Behavioural reference, compared every clock on the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      begin
        int lead, ws, c, expTag;
        bit inW, dark, valid;
        lead  = mL - (ACT + 2 * GRD);
        ws    = lead + GRD;
        inW   = (mH >= ws) && (mH < ws + ACT);
        dark  = (mV == 0) || (mV == VALID + 1);
        valid = (mV >= 1) && (mV <= VALID);
        c     = inW ? (mH - ws) : 0;
        expTag = 0;
        if (inW && valid && !monochrome) expTag = ((mV % 2) == 1) ? (c % 2) : 2 + (c % 2);
        check("R2 R3 R7 pixValid", int'(pixValid), int'(inW && (dark || valid)));
        check("R7 hSync", int'(hSync), int'(inW && (dark || valid)));
        check("R6 vSync", int'(vSync), int'(mV == 0 && mH >= lead - LEAD && mH < lead));
        check("R8 darkLine", int'(darkLine), int'(inW && dark));
        check("R4 R5 rowIdx", int'(rowIdx), mV);
        check("R9 colIdx", int'(colIdx), c);
        check("R10 colorTag", int'(colorTag), expTag);
      end
      if (!rstN) begin
        mH = 0; mV = 0; mL = MINL; mF = MINF;
      end else if (mH == mL - 1) begin
        mH = 0;
        if (mV == mF - 1) begin
          mV = 0;
          mL = clampLine(int'(cfgLineLen));
          mF = clampFrame(int'(cfgFrameLen));
        end else mV++;
      end else mH++;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    waitCyc(4);
    @(negedge clk); #0.5;
    // R1: reset state
    check("R1 reset pixValid", int'(pixValid), 0);
    check("R1 reset rowIdx", int'(rowIdx), 0);
    check("R1 reset colIdx", int'(colIdx), 0);
    check("R1 reset darkLine", int'(darkLine), 0);
    waitCyc(1);
    rstN = 1;
    waitCyc(250);
    // R3 R5: below minimum requests clamp up
    cfgLineLen = HW'(3); cfgFrameLen = FW'(2);
    waitCyc(260);
    // longer lead run and blank lines between frames
    cfgLineLen = HW'(23); cfgFrameLen = FW'(9);
    waitCyc(650);
    monochrome = 1;
    waitCyc(300);
    monochrome = 0;
    // R3: above maximum clamps down; changes land mid-frame
    cfgLineLen = HW'(31); cfgFrameLen = FW'(12);
    waitCyc(1213);
    cfgLineLen = HW'(20); cfgFrameLen = FW'(7);
    waitCyc(77);
    cfgLineLen = HW'(25);
    waitCyc(600);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule